// File: doc/BRIEF.md
# Serial Memory Program-and-Verify Sequencer

This block writes a run of host bytes into a serial EEPROM or flash device and proves every byte landed. A single start pulse supplies the first device address, a byte count, the page size (as a base-two exponent) and a device select. The bytes arrive on a valid/ready stream. The block works through the run one chunk at a time. For each chunk it takes that chunk's bytes from the stream into a local store. It then asks a serial command engine to latch write enable and to program the chunk. Next it polls the device's status byte until the device reports ready. Last, it reads the chunk back and compares it with the store.

A chunk never crosses a page boundary and never exceeds the engine's 16-byte data window. The address advances only after the read-back matches. The run ends in one of three ways: a one-cycle completion pulse, a sticky timeout error when the device stays busy too long, or a sticky verify error. Either error stops the run at once, and the offending device address is held for inspection. The command engine sits behind a request/acknowledge port. A request and its fields stay steady until the engine acknowledges. Read data returns with the acknowledge.

Top module: `spv_prog_verify`

## Requirements
- R1: Before every chunk program command, the block issues a write-enable request with opcode 0x06, command address 0 and length 0. It then issues a program request with opcode 0x02, the chunk's device address and length, and cmd_rd low.
- R2: The chunk length is the smallest of three values: the bytes still to write, 16, and the bytes left to the end of the current page (page size minus the address modulo page size, where page size is 2 to the power page_log2).
- R3: After each program command, the block issues status polls with opcode 0x05, address 0, length 1 and cmd_rd high. Only bit 0 of the returned byte 0 is consulted (1 = device busy). Bit 1, bits 2 to 4 and bit 7 have no effect. After a busy result, the next poll request appears exactly POLL_GAP+1 clock cycles after the cycle in which the busy result was acknowledged.
- R4: If MAX_POLLS consecutive polls for one chunk all report busy, err_timeout is set and fail_addr holds that chunk's start address. No further command is issued, and busy falls.
- R5: Once the device is ready, the block issues a read-back with opcode 0x03, the same address and length, and cmd_rd high. If any returned byte within the chunk length differs from the stored byte, err_verify is set, fail_addr holds the address of the lowest differing byte, and the run stops with no further command.
- R6: After a matching read-back, the address advances by the chunk length. When the final chunk verifies, done pulses for exactly one cycle, busy is low, and the device holds every source byte at its address.
- R7: A start with byte_count 0 produces a done pulse on the next cycle and issues no command.
- R8: src_ready is high only while a chunk is being loaded, and never together with cmd_req. Exactly one chunk length of bytes is taken per chunk. Chunk byte i travels in cmd_wdata[8i+7:8i], is compared against cmd_rdata[8i+7:8i], and belongs to address chunk start + i.
- R9: After reset, busy, done, err_timeout, err_verify, cmd_req and src_ready are all low.
- R10: While cmd_req is high and unacknowledged, cmd_req and the opcode, address and length fields stay unchanged. Every request carries the dev_sel value captured at start.
- R11: A start clears both error flags and fail_addr. err_timeout and err_verify are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken only while idle) |
| start_addr | input | AW | First device address |
| byte_count | input | LW | Number of bytes to program |
| page_log2 | input | PLW | Base-two exponent of the device page size |
| dev_sel | input | 1 | Device select forwarded to the engine |
| src_valid | input | 1 | Source byte present |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Block accepts a source byte |
| cmd_req | output | 1 | Command request to the engine |
| cmd_op | output | 8 | Command opcode |
| cmd_rd | output | 1 | Command returns data |
| cmd_sel | output | 1 | Device select for the command |
| cmd_addr | output | AW | Command device address |
| cmd_len | output | $clog2(CHUNK_BYTES+1) | Data byte count of the command |
| cmd_wdata | output | 8*CHUNK_BYTES | Program data, byte i in lane i |
| cmd_ack | input | 1 | Engine finished the request |
| cmd_rdata | input | 8*CHUNK_BYTES | Returned bytes, valid with cmd_ack |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Sticky device-busy timeout |
| err_verify | output | 1 | Sticky read-back mismatch |
| fail_addr | output | AW | Address tied to the recorded error |

## Verification
The assertions assume that the engine raises cmd_ack only while cmd_req is high, for a single cycle, and that the requested chunk fits inside one page, which holds only when page_log2 is below AW. The bench's engine model acknowledges one or more cycles after it first sees a request and drops the acknowledge on the following cycle. Its page exponents run from 0 to 8. The model also sets the protect and latch bits in every status reply, and can corrupt one read-back byte, which drives the error paths without breaking the handshake.

// File: rtl/spv_pkg.sv
package spv_pkg;
    // engine data window in bytes
    localparam int CHUNK_BYTES_DEF = 16;

    // command opcodes
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_STAT  = 8'h05;
    localparam logic [7:0] OP_FETCH = 8'h03;

    // status byte: device busy flag position
    localparam int BUSY_BIT = 0;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_WREN,
        SQ_PROG,
        SQ_STAT,
        SQ_GAP,
        SQ_FETCH
    } seq_state_e;

    typedef struct packed {
        logic [7:0] op;
        logic       rd;
        logic       with_addr;
        logic       with_data;
    } cmd_kind_t;

    function automatic cmd_kind_t kind_of(input seq_state_e st);
        cmd_kind_t k;
        k = '{op: 8'h00, rd: 1'b0, with_addr: 1'b0, with_data: 1'b0};
        case (st)
            SQ_WREN:  k = '{op: OP_WREN,  rd: 1'b0, with_addr: 1'b0, with_data: 1'b0};
            SQ_PROG:  k = '{op: OP_PROG,  rd: 1'b0, with_addr: 1'b1, with_data: 1'b1};
            SQ_STAT:  k = '{op: OP_STAT,  rd: 1'b1, with_addr: 1'b0, with_data: 1'b0};
            SQ_FETCH: k = '{op: OP_FETCH, rd: 1'b1, with_addr: 1'b1, with_data: 1'b1};
            default:  k = '{op: 8'h00, rd: 1'b0, with_addr: 1'b0, with_data: 1'b0};
        endcase
        return k;
    endfunction

    function automatic logic is_cmd_state(input seq_state_e st);
        return (st == SQ_WREN) || (st == SQ_PROG) || (st == SQ_STAT) || (st == SQ_FETCH);
    endfunction
endpackage

// File: rtl/spv_chunk_calc.sv
module spv_chunk_calc #(
    parameter int AW  = 24,
    parameter int LW  = 16,
    parameter int PLW = 4,
    parameter int NB  = 16,
    parameter int CLW = $clog2(NB + 1)
) (
    input  logic [AW-1:0]  addr,
    input  logic [LW-1:0]  remain,
    input  logic [PLW-1:0] page_log2,
    output logic [CLW-1:0] chunk_len
);
    localparam int CW = ((AW > LW) ? AW : LW) + 1;

    logic [CW-1:0] page_sz;
    logic [CW-1:0] page_left;
    logic [CW-1:0] pick;

    always_comb begin
        page_sz   = CW'(1) << page_log2;
        page_left = page_sz - (CW'(addr) & (page_sz - CW'(1)));
        pick      = CW'(NB);
        if (page_left < pick) pick = page_left;
        if (CW'(remain) < pick) pick = CW'(remain);
        chunk_len = pick[CLW-1:0];
    end
endmodule

// File: rtl/spv_chunk_store.sv
module spv_chunk_store #(
    parameter int NB  = 16,
    parameter int IW  = $clog2(NB),
    parameter int CLW = $clog2(NB + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [7:0]      wr_byte,
    input  logic [8*NB-1:0] cmp_data,
    input  logic [CLW-1:0]  cmp_len,
    output logic [8*NB-1:0] held,
    output logic            mismatch,
    output logic [IW-1:0]   mis_idx
);
    logic [7:0]    lane_q [NB];
    logic [NB-1:0] differs;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NB; i++) begin
            if (rst) begin
                lane_q[i] <= 8'h00;
            end else if (wr_en && (wr_idx == IW'(i))) begin
                lane_q[i] <= wr_byte;
            end
        end
    end

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign held[8*g +: 8] = lane_q[g];
        assign differs[g]     = (CLW'(g) < cmp_len) && (cmp_data[8*g +: 8] != lane_q[g]);
    end

    // lowest differing lane wins
    always_comb begin
        mis_idx = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (differs[i]) mis_idx = IW'(i);
        end
        mismatch = |differs;
    end
endmodule

// File: rtl/spv_poll_timer.sv
module spv_poll_timer #(
    parameter int GAP_CYC   = 100000,
    parameter int MAX_POLLS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic poll_seen,
    input  logic in_gap,
    output logic gap_over,
    output logic last_poll
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [GW-1:0] gap_q;
    logic [PW-1:0] polls_q;

    always_ff @(posedge clk) begin
        if (rst || !in_gap) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + GW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            polls_q <= '0;
        end else if (poll_seen) begin
            polls_q <= polls_q + PW'(1);
        end
    end

    assign gap_over  = in_gap && (gap_q == GW'(GAP_CYC - 1));
    assign last_poll = (polls_q == PW'(MAX_POLLS - 1));

    // R4
    poll_cap_chk: assert property (@(posedge clk) disable iff (rst)
        polls_q <= PW'(MAX_POLLS));

    // R3
    gap_len_chk: assert property (@(posedge clk) disable iff (rst)
        in_gap |-> gap_q < GW'(GAP_CYC));
endmodule

// File: rtl/spv_prog_verify.sv
module spv_prog_verify
    import spv_pkg::*;
#(
    parameter int AW          = 24,
    parameter int LW          = 16,
    parameter int PLW         = 4,
    parameter int CHUNK_BYTES = spv_pkg::CHUNK_BYTES_DEF,
    parameter int POLL_GAP    = 100000,
    parameter int MAX_POLLS   = 20
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  logic [AW-1:0]                     start_addr,
    input  logic [LW-1:0]                     byte_count,
    input  logic [PLW-1:0]                    page_log2,
    input  logic                              dev_sel,
    input  logic                              src_valid,
    input  logic [7:0]                        src_data,
    output logic                              src_ready,
    output logic                              cmd_req,
    output logic [7:0]                        cmd_op,
    output logic                              cmd_rd,
    output logic                              cmd_sel,
    output logic [AW-1:0]                     cmd_addr,
    output logic [$clog2(CHUNK_BYTES+1)-1:0]  cmd_len,
    output logic [8*CHUNK_BYTES-1:0]          cmd_wdata,
    input  logic                              cmd_ack,
    input  logic [8*CHUNK_BYTES-1:0]          cmd_rdata,
    output logic                              busy,
    output logic                              done,
    output logic                              err_timeout,
    output logic                              err_verify,
    output logic [AW-1:0]                     fail_addr
);
    localparam int CLW = $clog2(CHUNK_BYTES + 1);
    localparam int IW  = $clog2(CHUNK_BYTES);
    localparam int AW1 = AW + 1;

    seq_state_e     state_q;
    logic [AW-1:0]  addr_q;
    logic [LW-1:0]  rem_q;
    logic [PLW-1:0] page_q;
    logic           sel_q;
    logic [CLW-1:0] ld_cnt_q;
    logic           done_q;
    logic           err_to_q;
    logic           err_vf_q;
    logic [AW-1:0]  fail_q;

    logic [CLW-1:0]           clen;
    logic [8*CHUNK_BYTES-1:0] held;
    logic                     mismatch;
    logic [IW-1:0]            mis_idx;
    logic                     gap_over;
    logic                     last_poll;
    logic                     take_byte;
    logic                     dev_busy;
    cmd_kind_t                kind;

    spv_chunk_calc #(.AW(AW), .LW(LW), .PLW(PLW), .NB(CHUNK_BYTES), .CLW(CLW)) calc_i (
        .addr      (addr_q),
        .remain    (rem_q),
        .page_log2 (page_q),
        .chunk_len (clen)
    );

    assign take_byte = (state_q == SQ_LOAD) && src_valid;

    spv_chunk_store #(.NB(CHUNK_BYTES), .IW(IW), .CLW(CLW)) store_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (take_byte),
        .wr_idx   (ld_cnt_q[IW-1:0]),
        .wr_byte  (src_data),
        .cmp_data (cmd_rdata),
        .cmp_len  (clen),
        .held     (held),
        .mismatch (mismatch),
        .mis_idx  (mis_idx)
    );

    spv_poll_timer #(.GAP_CYC(POLL_GAP), .MAX_POLLS(MAX_POLLS)) timer_i (
        .clk       (clk),
        .rst       (rst),
        .restart   ((state_q == SQ_PROG) && cmd_ack),
        .poll_seen ((state_q == SQ_STAT) && cmd_ack),
        .in_gap    (state_q == SQ_GAP),
        .gap_over  (gap_over),
        .last_poll (last_poll)
    );

    // command port decode
    always_comb begin
        kind      = kind_of(state_q);
        cmd_req   = is_cmd_state(state_q);
        cmd_op    = kind.op;
        cmd_rd    = kind.rd;
        cmd_sel   = sel_q;
        cmd_addr  = kind.with_addr ? addr_q : '0;
        cmd_len   = kind.with_data ? clen : ((state_q == SQ_STAT) ? CLW'(1) : '0);
        cmd_wdata = (state_q == SQ_PROG) ? held : '0;
    end

    assign dev_busy    = cmd_rdata[BUSY_BIT];
    assign src_ready   = (state_q == SQ_LOAD);
    assign busy        = (state_q != SQ_IDLE);
    assign done        = done_q;
    assign err_timeout = err_to_q;
    assign err_verify  = err_vf_q;
    assign fail_addr   = fail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            addr_q   <= '0;
            rem_q    <= '0;
            page_q   <= '0;
            sel_q    <= 1'b0;
            ld_cnt_q <= '0;
            done_q   <= 1'b0;
            err_to_q <= 1'b0;
            err_vf_q <= 1'b0;
            fail_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        addr_q   <= start_addr;
                        rem_q    <= byte_count;
                        page_q   <= page_log2;
                        sel_q    <= dev_sel;
                        ld_cnt_q <= '0;
                        err_to_q <= 1'b0;
                        err_vf_q <= 1'b0;
                        fail_q   <= '0;
                        if (byte_count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= SQ_LOAD;
                        end
                    end
                end
                SQ_LOAD: begin
                    if (src_valid) begin
                        ld_cnt_q <= ld_cnt_q + CLW'(1);
                        if (ld_cnt_q == clen - CLW'(1)) state_q <= SQ_WREN;
                    end
                end
                SQ_WREN: if (cmd_ack) state_q <= SQ_PROG;
                SQ_PROG: if (cmd_ack) state_q <= SQ_STAT;
                SQ_STAT: begin
                    if (cmd_ack) begin
                        if (!dev_busy) begin
                            state_q <= SQ_FETCH;
                        end else if (last_poll) begin
                            err_to_q <= 1'b1;
                            fail_q   <= addr_q;
                            state_q  <= SQ_IDLE;
                        end else begin
                            state_q <= SQ_GAP;
                        end
                    end
                end
                SQ_GAP: if (gap_over) state_q <= SQ_STAT;
                SQ_FETCH: begin
                    if (cmd_ack) begin
                        if (mismatch) begin
                            err_vf_q <= 1'b1;
                            fail_q   <= addr_q + AW'(mis_idx);
                            state_q  <= SQ_IDLE;
                        end else begin
                            addr_q   <= addr_q + AW'(clen);
                            rem_q    <= rem_q - LW'(clen);
                            ld_cnt_q <= '0;
                            if (rem_q == LW'(clen)) begin
                                done_q  <= 1'b1;
                                state_q <= SQ_IDLE;
                            end else begin
                                state_q <= SQ_LOAD;
                            end
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // assertion helpers: page span of the outgoing program request
    logic [AW1-1:0] chk_psz;
    logic [AW1-1:0] chk_end;
    always_comb begin
        chk_psz = AW1'(1) << page_q;
        chk_end = ({1'b0, cmd_addr} & (chk_psz - AW1'(1))) + AW1'(cmd_len);
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_len)));

    // R10 (engine protocol)
    ack_legal_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_ack |-> cmd_req);

    // R2
    chunk_span_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && cmd_op == OP_PROG) |-> (cmd_len != '0 && cmd_len <= CLW'(CHUNK_BYTES) && chk_end <= chk_psz));

    // R8
    load_excl_chk: assert property (@(posedge clk) disable iff (rst)
        src_ready |-> !cmd_req);

    // R11
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(err_timeout && err_verify));

    // R6
    done_clean_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !err_timeout && !err_verify));

    // R4
    stop_on_err_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(err_timeout) || $rose(err_verify)) |-> !busy);
endmodule

// File: tb/spv_prog_verify_tb.sv
module spv_prog_verify_tb_top;
    localparam int AW = 24;
    localparam int LW = 16;
    localparam int PLW = 4;
    localparam int NB = 16;
    localparam int CLW = $clog2(NB + 1);
    localparam int GAP = 6;
    localparam int MAXP = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [LW-1:0] byte_count = '0;
    logic [PLW-1:0] page_log2 = '0;
    logic dev_sel = 1'b0;
    logic src_valid = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic src_ready;
    logic cmd_req, cmd_rd, cmd_sel;
    logic [7:0] cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [CLW-1:0] cmd_len;
    logic [8*NB-1:0] cmd_wdata;
    logic cmd_ack = 1'b0;
    logic [8*NB-1:0] cmd_rdata = '0;
    logic busy, done, err_timeout, err_verify;
    logic [AW-1:0] fail_addr;

    always #5 clk = ~clk;

    spv_prog_verify #(.AW(AW), .LW(LW), .PLW(PLW), .CHUNK_BYTES(NB),
                      .POLL_GAP(GAP), .MAX_POLLS(MAXP)) dut_i (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .page_log2(page_log2), .dev_sel(dev_sel),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_rd(cmd_rd), .cmd_sel(cmd_sel),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata),
        .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata), .busy(busy), .done(done),
        .err_timeout(err_timeout), .err_verify(err_verify), .fail_addr(fail_addr)
    );

    typedef struct {
        logic [7:0] op;
        int         addr;
        int         len;
        int         off;
    } exp_cmd_t;

    int n_checks = 0;
    int n_fails = 0;
    int cyc = 0;
    int done_cnt = 0;
    logic [7:0] mem [int];
    logic [7:0] srcbuf [$];
    logic [7:0] src_q [$];
    exp_cmd_t exp_q [$];
    int cfg_busy_polls = 0;
    int cfg_corrupt = -1;
    int cfg_delay = 0;
    bit cfg_gaps = 0;
    logic cur_sel = 1'b0;
    int polls_left = 0;
    int delay_cnt = 0;
    int gap_ref = -1;
    logic rdy_prev = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] mem_rd(input int a);
        if (mem.exists(a)) return mem[a];
        return 8'hFF;
    endfunction

    // engine model, source stream and monitors; all on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (done) done_cnt++;
            // source stream: transfer happened at the last rising edge
            if (src_valid && rdy_prev && src_q.size() > 0) void'(src_q.pop_front());
            src_valid = (src_q.size() > 0) && !(cfg_gaps && (cyc % 3 == 0));
            src_data  = (src_q.size() > 0) ? src_q[0] : 8'h00;
            rdy_prev  = src_ready;
            // command engine
            if (cmd_ack) begin
                cmd_ack = 1'b0;
            end else if (cmd_req) begin
                if (delay_cnt == 0 && cmd_op == 8'h05 && gap_ref >= 0) begin
                    // R3 poll spacing
                    check(cyc - gap_ref == GAP + 1, "R3 poll spacing", cyc - gap_ref, GAP + 1);
                    gap_ref = -1;
                end
                if (delay_cnt < cfg_delay) begin
                    delay_cnt++;
                end else begin
                    exp_cmd_t e;
                    delay_cnt = 0;
                    if (exp_q.size() == 0) begin
                        check(0, "R4/R5 unexpected command", cmd_op, 0);
                    end else begin
                        e = exp_q.pop_front();
                        // R1 R3 R5 command fields; R10 select
                        check(cmd_op == e.op, "R1/R3/R5 opcode", cmd_op, e.op);
                        check(int'(cmd_addr) == e.addr && int'(cmd_len) == e.len,
                              "R2 address/length", {cmd_addr, 8'(cmd_len)}, {e.addr[23:0], 8'(e.len)});
                        check(cmd_rd == (e.op == 8'h05 || e.op == 8'h03), "R1 direction", cmd_rd, 0);
                        check(cmd_sel == cur_sel, "R10 select", cmd_sel, cur_sel);
                    end
                    cmd_rdata = '0;
                    case (cmd_op)
                        8'h02: begin
                            for (int i = 0; i < int'(cmd_len); i++) begin
                                mem[int'(cmd_addr) + i] = cmd_wdata[8*i +: 8];
                                // R8 lane order
                                if (e.op == 8'h02)
                                    check(cmd_wdata[8*i +: 8] == srcbuf[e.off + i], "R8 program lane",
                                          cmd_wdata[8*i +: 8], srcbuf[e.off + i]);
                            end
                            polls_left = cfg_busy_polls;
                        end
                        8'h05: begin
                            if (polls_left > 0) begin
                                polls_left--;
                                cmd_rdata[7:0] = 8'h9F;
                                gap_ref = cyc;
                            end else begin
                                cmd_rdata[7:0] = 8'h9E;
                            end
                        end
                        8'h03: begin
                            for (int i = 0; i < int'(cmd_len); i++) begin
                                cmd_rdata[8*i +: 8] = mem_rd(int'(cmd_addr) + i);
                                if (int'(cmd_addr) + i == cfg_corrupt)
                                    cmd_rdata[8*i +: 8] = cmd_rdata[8*i +: 8] ^ 8'h40;
                            end
                        end
                        default: ;
                    endcase
                    cmd_ack = 1'b1;
                end
            end
        end
    end

    task automatic run_op(input int a0, input int len, input int plog, input logic sel,
                          input int nbusy, input int corrupt, input bit gaps, input int dly,
                          input int seed);
        int a, r, off, psz, c, np, kind, efail, d0, waited;
        srcbuf.delete();
        src_q.delete();
        exp_q.delete();
        for (int i = 0; i < len; i++) srcbuf.push_back(8'((seed * 7 + i * 13 + 5) & 255));
        foreach (srcbuf[i]) src_q.push_back(srcbuf[i]);
        cfg_busy_polls = nbusy; cfg_corrupt = corrupt; cfg_gaps = gaps; cfg_delay = dly;
        cur_sel = sel; gap_ref = -1;
        // independent expectation
        a = a0; r = len; off = 0; psz = 1 << plog; kind = 0; efail = 0;
        while (r > 0) begin
            c = 16;
            if (psz - (a % psz) < c) c = psz - (a % psz);
            if (r < c) c = r;
            exp_q.push_back('{op: 8'h06, addr: 0, len: 0, off: 0});
            exp_q.push_back('{op: 8'h02, addr: a, len: c, off: off});
            np = (nbusy >= MAXP) ? MAXP : nbusy + 1;
            for (int k = 0; k < np; k++) exp_q.push_back('{op: 8'h05, addr: 0, len: 1, off: 0});
            if (nbusy >= MAXP) begin kind = 1; efail = a; break; end
            exp_q.push_back('{op: 8'h03, addr: a, len: c, off: off});
            if (corrupt >= a && corrupt < a + c) begin kind = 2; efail = corrupt; break; end
            a += c; r -= c; off += c;
        end
        d0 = done_cnt;
        @(negedge clk);
        start_addr = AW'(a0); byte_count = LW'(len); page_log2 = PLW'(plog); dev_sel = sel;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R11 errors cleared by start
        check(!err_timeout && !err_verify && fail_addr == '0, "R11 clear on start",
              {err_timeout, err_verify}, 0);
        if (len == 0) begin
            // R7
            check(done && !busy, "R7 zero length done", {done, busy}, 2'b10);
        end
        waited = 0;
        while ((busy || (done_cnt == d0 && !err_timeout && !err_verify && len != 0)) && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R4/R5/R6 command count", exp_q.size(), 0);
        if (kind == 0) begin
            check(done_cnt == d0 + 1, "R6 single done pulse", done_cnt - d0, 1);
            check(!err_timeout && !err_verify, "R6 no error", {err_timeout, err_verify}, 0);
            check(src_q.size() == 0, "R8 all bytes taken", src_q.size(), 0);
            for (int i = 0; i < len; i++)
                check(mem_rd(a0 + i) == srcbuf[i], "R6 device contents", mem_rd(a0 + i), srcbuf[i]);
        end else if (kind == 1) begin
            check(err_timeout && !err_verify && !busy, "R4 timeout flag", {err_timeout, err_verify}, 2'b10);
            check(int'(fail_addr) == efail, "R4 fail address", fail_addr, efail);
            check(done_cnt == d0, "R4 no done", done_cnt - d0, 0);
        end else begin
            check(err_verify && !err_timeout && !busy, "R5 verify flag", {err_timeout, err_verify}, 2'b01);
            check(int'(fail_addr) == efail, "R5 fail address", fail_addr, efail);
            check(done_cnt == d0, "R5 no done", done_cnt - d0, 0);
        end
        src_q.delete();
        cfg_corrupt = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9
        check(!busy && !done && !err_timeout && !err_verify && !cmd_req && !src_ready,
              "R9 reset state", {busy, done, err_timeout, err_verify, cmd_req, src_ready}, 0);
        run_op(32'h100, 32, 4, 1'b1, 0, -1, 0, 0, 1);   // R2 16-byte chunks
        run_op(32'h1A, 40, 5, 1'b0, 1, -1, 1, 1, 2);    // R2 page split, stream gaps
        run_op(32'h3, 20, 3, 1'b1, 3, -1, 0, 0, 3);     // R3 busy polls
        run_op(32'h80, 0, 4, 1'b0, 0, -1, 0, 0, 4);     // R7
        run_op(32'h200, 10, 4, 1'b1, 25, -1, 0, 0, 5);  // R4 timeout
        run_op(32'h40, 16, 8, 1'b0, 0, -1, 0, 2, 6);    // R11 recovery
        run_op(32'h300, 24, 4, 1'b1, 0, 32'h313, 0, 0, 7); // R5 mismatch
        run_op(32'h50, 3, 0, 1'b0, 2, -1, 1, 0, 8);     // R2 one-byte pages
        run_op(32'h0F0, 300, 8, 1'b1, 0, -1, 0, 0, 9);  // R6 long run
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule